// File: doc/BRIEF.md
# Calendar Alarm Comparator with Interrupt

This block holds a wake-up time as seven BCD fields laid out like the calendar counter: seconds, minutes, hours, weekday, day of month, month and year. Software first writes the fields into a staging copy. Each field carries its own compare-enable flag. A separate commit write then moves the whole staged set into the active alarm in one step, so the comparator never sees a half-written alarm.

On every calendar update strobe the active alarm is compared with the running calendar, which another block supplies as input fields. Only the fields whose flag is set take part. When every enabled field is equal, a sticky status flag is set. Software clears it by writing 1 to it. The interrupt line is the status flag gated by an interrupt-enable bit.

The calendar update is a plain one-cycle strobe and cannot be stalled. The register port is a simple single-cycle write strobe with a combinational read mux, with no back-pressure on either side.

Top module: `cal_alarm_top`

## Requirements
- R1: After reset every active field reads 0 with its flag clear, the interrupt enable and the status read 0, and `irq_o` is low.
- R2: Writing address g (0 = seconds, 1 = minutes, 2 = hours, 3 = weekday, 4 = day, 5 = month, 6 = year) loads only the staging copy. Bit 15 is the compare flag and the low bits hold the value, trimmed to the field width (7, 7, 6, 3, 6, 5, 8 bits). Reading address g returns the active field as {flag, 7'b0, zero-extended value}.
- R3: A write to address 7 with bit 15 set copies all staged fields and flags into the active alarm, and the copy is visible from the next cycle. A write to address 7 with bit 15 clear changes nothing.
- R4: When `cal_tick_i` is high and every flagged active field equals its calendar input, the status flag is 1 from the next cycle.
- R5: A field whose flag is clear, for example the weekday, does not affect the match result.
- R6: With no field flagged, the status flag is never set.
- R7: When `cal_tick_i` is low, the status flag is not set, even if the fields are equal.
- R8: The status flag is set on a match whatever the interrupt enable is. `irq_o` equals status AND enable (bit 0 of address 8).
- R9: Writing address 9 with bit 0 = 1 clears the status flag. Writing it with bit 0 = 0 leaves the flag unchanged.
- R10: If a clearing write to address 9 and a match happen in the same cycle, the status flag stays 1.
- R11: Address 8 reads back the enable in bit 0, and address 9 reads back the status in bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 4 | Register write address |
| wr_data_i | input | 16 | Register write data |
| rd_addr_i | input | 4 | Register read address |
| rd_data_o | output | 16 | Register read data (combinational) |
| cal_tick_i | input | 1 | One-cycle calendar update strobe |
| cal_sec_i | input | 7 | Calendar seconds, BCD |
| cal_min_i | input | 7 | Calendar minutes, BCD |
| cal_hour_i | input | 6 | Calendar hours, BCD |
| cal_wday_i | input | 3 | Calendar weekday |
| cal_day_i | input | 6 | Calendar day of month, BCD |
| cal_mon_i | input | 5 | Calendar month, BCD |
| cal_year_i | input | 8 | Calendar year, BCD |
| irq_o | output | 1 | Alarm interrupt |

## Verification
The assertions check on every cycle that the active alarm does not move without a commit. They also check that a qualified match always leaves the status flag set, that a clear with no match drops it, and that a match wins over a clear. Finally, they check that the flag cannot rise without a strobe or with no field flagged. Only the bench's scenarios can show that the match itself is correct. These cover random alarms and flag sets against calendars that agree or differ in selected fields, the value trimming and readback layout, the commit gating on bit 15, and the gating of the interrupt by the enable bit.

// File: rtl/cal_alarm_pkg.sv
package cal_alarm_pkg;
  localparam int NFIELD   = 7;
  localparam int SLOT_W   = 8;
  localparam int ADDR_W   = 4;
  localparam int DATA_W   = 16;
  localparam int FLAG_BIT = 15;
  localparam int A_COMMIT = 7;
  localparam int A_IRQEN  = 8;
  localparam int A_STATUS = 9;

  // BCD width of each calendar slot, in slot order
  function automatic int slot_width(input int idx);
    case (idx)
      0, 1:    return 7;
      2, 4:    return 6;
      3:       return 3;
      5:       return 5;
      default: return 8;
    endcase
  endfunction
endpackage

// File: rtl/cal_alarm_slot.sv
module cal_alarm_slot #(
  parameter int W = 7
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         sel_i,
  input  logic [W-1:0] val_i,
  input  logic         flag_i,
  input  logic         commit_i,
  output logic [W-1:0] act_val_o,
  output logic         act_flag_o
);
  logic [W-1:0] stg_val;
  logic         stg_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stg_val  <= '0;
      stg_flag <= 1'b0;
    end else if (sel_i) begin
      stg_val  <= val_i;
      stg_flag <= flag_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_val_o  <= '0;
      act_flag_o <= 1'b0;
    end else if (commit_i) begin
      act_val_o  <= stg_val;
      act_flag_o <= stg_flag;
    end
  end

  // R3: active copy only moves on a commit
  a_r3_hold_without_commit: assert property (@(posedge clk) disable iff (!rst_n)
    !commit_i |=> ($stable(act_val_o) && $stable(act_flag_o)));
endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match #(
  parameter int NF = 7,
  parameter int SW = 8
) (
  input  logic [NF*SW-1:0] alarm_i,
  input  logic [NF-1:0]    flag_i,
  input  logic [NF*SW-1:0] cal_i,
  input  logic             tick_i,
  output logic             hit_o
);
  logic [NF-1:0] agree;

  for (genvar g = 0; g < NF; g++) begin : g_cmp
    assign agree[g] = !flag_i[g] || (alarm_i[g*SW +: SW] == cal_i[g*SW +: SW]);
  end

  assign hit_o = tick_i && (|flag_i) && (&agree);
endmodule

// File: rtl/cal_alarm_irq.sv
module cal_alarm_irq (
  input  logic clk,
  input  logic rst_n,
  input  logic hit_i,
  input  logic clr_i,
  input  logic en_wr_i,
  input  logic en_val_i,
  output logic status_o,
  output logic en_o,
  output logic irq_o
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       status_o <= 1'b0;
    else if (hit_i)   status_o <= 1'b1;
    else if (clr_i)   status_o <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        en_o <= 1'b0;
    else if (en_wr_i)  en_o <= en_val_i;
  end

  assign irq_o = status_o && en_o;

  a_r4_hit_sets_status: assert property (@(posedge clk) disable iff (!rst_n)
    hit_i |=> status_o);
  a_r9_clear_drops_status: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !hit_i) |=> !status_o);
  a_r10_hit_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && hit_i) |=> status_o);
endmodule

// File: rtl/cal_alarm_top.sv
module cal_alarm_top
  import cal_alarm_pkg::*;
#(
  parameter int AW = ADDR_W,
  parameter int DW = DATA_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [AW-1:0] wr_addr_i,
  input  logic [DW-1:0] wr_data_i,
  input  logic [AW-1:0] rd_addr_i,
  output logic [DW-1:0] rd_data_o,
  input  logic          cal_tick_i,
  input  logic [6:0]    cal_sec_i,
  input  logic [6:0]    cal_min_i,
  input  logic [5:0]    cal_hour_i,
  input  logic [2:0]    cal_wday_i,
  input  logic [5:0]    cal_day_i,
  input  logic [4:0]    cal_mon_i,
  input  logic [7:0]    cal_year_i,
  output logic          irq_o
);
  localparam int TOTW = NFIELD * SLOT_W;
  localparam int PADW = DW - SLOT_W - 1;

  logic [TOTW-1:0]   alarm_flat;
  logic [TOTW-1:0]   cal_flat;
  logic [NFIELD-1:0] alarm_flag;
  logic              commit, hit, clr, en_wr, status_q, irq_en_q;
  logic              unused_wbits;

  assign unused_wbits = ^wr_data_i[FLAG_BIT-1:SLOT_W];

  assign cal_flat[0*SLOT_W +: SLOT_W] = SLOT_W'(cal_sec_i);
  assign cal_flat[1*SLOT_W +: SLOT_W] = SLOT_W'(cal_min_i);
  assign cal_flat[2*SLOT_W +: SLOT_W] = SLOT_W'(cal_hour_i);
  assign cal_flat[3*SLOT_W +: SLOT_W] = SLOT_W'(cal_wday_i);
  assign cal_flat[4*SLOT_W +: SLOT_W] = SLOT_W'(cal_day_i);
  assign cal_flat[5*SLOT_W +: SLOT_W] = SLOT_W'(cal_mon_i);
  assign cal_flat[6*SLOT_W +: SLOT_W] = SLOT_W'(cal_year_i);

  assign commit = wr_en_i && (wr_addr_i == AW'(A_COMMIT)) && wr_data_i[FLAG_BIT];
  assign clr    = wr_en_i && (wr_addr_i == AW'(A_STATUS)) && wr_data_i[0];
  assign en_wr  = wr_en_i && (wr_addr_i == AW'(A_IRQEN));

  for (genvar g = 0; g < NFIELD; g++) begin : g_slot
    localparam int W = slot_width(g);
    logic [W-1:0] act_val;

    cal_alarm_slot #(.W(W)) u_slot (
      .clk        (clk),
      .rst_n      (rst_n),
      .sel_i      (wr_en_i && (wr_addr_i == AW'(g))),
      .val_i      (wr_data_i[W-1:0]),
      .flag_i     (wr_data_i[FLAG_BIT]),
      .commit_i   (commit),
      .act_val_o  (act_val),
      .act_flag_o (alarm_flag[g])
    );
    assign alarm_flat[g*SLOT_W +: SLOT_W] = SLOT_W'(act_val);
  end

  cal_alarm_match #(.NF(NFIELD), .SW(SLOT_W)) u_match (
    .alarm_i (alarm_flat),
    .flag_i  (alarm_flag),
    .cal_i   (cal_flat),
    .tick_i  (cal_tick_i),
    .hit_o   (hit)
  );

  cal_alarm_irq u_irq (
    .clk      (clk),
    .rst_n    (rst_n),
    .hit_i    (hit),
    .clr_i    (clr),
    .en_wr_i  (en_wr),
    .en_val_i (wr_data_i[0]),
    .status_o (status_q),
    .en_o     (irq_en_q),
    .irq_o    (irq_o)
  );

  always_comb begin
    rd_data_o = '0;
    for (int i = 0; i < NFIELD; i++) begin
      if (rd_addr_i == AW'(i))
        rd_data_o = {alarm_flag[i], {PADW{1'b0}}, alarm_flat[i*SLOT_W +: SLOT_W]};
    end
    if (rd_addr_i == AW'(A_IRQEN))  rd_data_o = {{(DW-1){1'b0}}, irq_en_q};
    if (rd_addr_i == AW'(A_STATUS)) rd_data_o = {{(DW-1){1'b0}}, status_q};
  end

  // R6: nothing flagged means no new status
  a_r6_no_flag_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    ((alarm_flag == '0) && !status_q) |=> !status_q);
  // R7: no strobe means no new status
  a_r7_no_tick_no_set: assert property (@(posedge clk) disable iff (!rst_n)
    (!cal_tick_i && !status_q) |=> !status_q);
endmodule

// File: tb/test_cal_alarm_top.sv
module test_cal_alarm_top;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [3:0]  wr_addr = '0;
  logic [15:0] wr_data = '0;
  logic [3:0]  rd_addr = '0;
  logic [15:0] rd_data;
  logic        tick = 1'b0;
  logic [7:0]  cal_v [7];
  logic        irq;

  int tests = 0;
  int fails = 0;
  int m_val [7];
  bit m_flag [7];

  always #(PERIOD/2) clk = ~clk;

  cal_alarm_top i_cal_alarm_top (
    .clk(clk), .rst_n(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cal_tick_i(tick), .cal_sec_i(cal_v[0][6:0]), .cal_min_i(cal_v[1][6:0]),
    .cal_hour_i(cal_v[2][5:0]), .cal_wday_i(cal_v[3][2:0]),
    .cal_day_i(cal_v[4][5:0]), .cal_mon_i(cal_v[5][4:0]),
    .cal_year_i(cal_v[6][7:0]), .irq_o(irq)
  );

  function automatic int fw(input int i);
    case (i) 0, 1: return 7; 2, 4: return 6; 3: return 3; 5: return 5; default: return 8; endcase
  endfunction
  function automatic int fmask(input int i);
    return (1 << fw(i)) - 1;
  endfunction
  function automatic bit exp_hit();
    bit any = 0;
    bit all = 1;
    for (int i = 0; i < 7; i++) begin
      if (m_flag[i]) begin
        any = 1;
        if (int'(cal_v[i]) != m_val[i]) all = 0;
      end
    end
    return any && all;
  endfunction

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 4'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input int a, output logic [15:0] d);
    rd_addr = 4'(a);
    #1;
    d = rd_data;
  endtask

  task automatic pulse_tick();
    @(negedge clk);
    tick = 1'b1;
    @(negedge clk);
    tick = 1'b0;
  endtask

  // stage all fields from the model and commit
  task automatic load_alarm();
    for (int i = 0; i < 7; i++)
      wr(i, {m_flag[i], 7'b0, 8'(m_val[i])});
    wr(7, 16'h8000);
  endtask

  task automatic cal_equal();
    for (int i = 0; i < 7; i++) cal_v[i] = 8'(m_val[i]);
  endtask

  initial begin
    #(PERIOD * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [15:0] d;
    void'($urandom(32'd4242));
    for (int i = 0; i < 7; i++) cal_v[i] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    for (int i = 0; i < 7; i++) begin
      rd(i, d); check("R1 field", d, 16'h0000);
    end
    rd(8, d); check("R1 enable", d, 16'h0000);
    rd(9, d); check("R1 status", d, 16'h0000);
    check("R1 irq", {15'b0, irq}, 16'h0000);

    // R2 staging only, trimmed value; R3 commit gating
    wr(2, 16'h80FF);
    rd(2, d); check("R2 staged not active", d, 16'h0000);
    wr(7, 16'h0001);
    rd(2, d); check("R3 commit without bit15", d, 16'h0000);
    wr(7, 16'h8000);
    rd(2, d); check("R2 R3 committed trimmed", d, 16'h803F);
    wr(2, 16'h0000);
    wr(7, 16'h8000);
    rd(2, d); check("R3 recommit", d, 16'h0000);

    // R5 weekday unflagged, others match
    m_val = '{7'h30, 7'h15, 6'h12, 3'h4, 6'h21, 5'h06, 8'h24};
    m_flag = '{1, 1, 1, 0, 1, 1, 1};
    load_alarm();
    cal_equal();
    cal_v[3] = 8'h2;
    // R7 equal fields but no strobe
    @(negedge clk); @(negedge clk);
    rd(9, d); check("R7 no tick no status", d, 16'h0000);
    pulse_tick();
    rd(9, d); check("R5 R4 weekday ignored match", d, 16'h0001);
    check("R8 irq gated off", {15'b0, irq}, 16'h0000);
    wr(8, 16'h0001);
    rd(8, d); check("R11 enable readback", d, 16'h0001);
    check("R8 irq on", {15'b0, irq}, 16'h0001);
    // R9 write 0 keeps, write 1 clears
    wr(9, 16'h0000);
    rd(9, d); check("R9 write zero keeps", d, 16'h0001);
    wr(9, 16'h0001);
    rd(9, d); check("R9 clear", d, 16'h0000);
    check("R9 irq drops", {15'b0, irq}, 16'h0000);

    // R10 clear and match together
    @(negedge clk);
    tick = 1'b1; wr_en = 1'b1; wr_addr = 4'd9; wr_data = 16'h0001;
    @(negedge clk);
    tick = 1'b0; wr_en = 1'b0;
    rd(9, d); check("R10 match wins over clear", d, 16'h0001);
    wr(9, 16'h0001);

    // R4 one flagged field differs
    cal_v[0] = 8'h31;
    pulse_tick();
    rd(9, d); check("R4 mismatch no status", d, 16'h0000);

    // R6 nothing flagged, all equal
    m_flag = '{0, 0, 0, 0, 0, 0, 0};
    load_alarm();
    cal_equal();
    pulse_tick();
    rd(9, d); check("R6 no flags no status", d, 16'h0000);

    // random: R2 R4 R5 R8
    for (int it = 0; it < 60; it++) begin
      bit ie;
      bit e;
      ie = 1'($urandom);
      wr(8, {15'b0, ie});
      for (int i = 0; i < 7; i++) begin
        m_val[i] = int'($urandom) & fmask(i);
        m_flag[i] = ($urandom % 3) != 0;
        if (it % 10 == 0) m_flag[i] = 0;
      end
      load_alarm();
      for (int i = 0; i < 7; i++) begin
        rd(i, d); check("R2 random readback", d, {m_flag[i], 7'b0, 8'(m_val[i])});
      end
      cal_equal();
      for (int i = 0; i < 7; i++)
        if (($urandom % 4) == 0)
          cal_v[i] = 8'((m_val[i] + 1 + int'($urandom % 32'(fmask(i)))) & fmask(i));
      e = exp_hit();
      pulse_tick();
      rd(9, d); check("R4 R5 random match", d, {15'b0, e});
      check("R8 random irq", {15'b0, irq}, {15'b0, e & ie});
      wr(9, 16'h0001);
      rd(9, d); check("R9 random clear", d, 16'h0000);
    end

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule